// File: doc/BRIEF.md
# Two-Cycle Flash Command Interpreter

This block is the control side of a byte-wide flash memory that takes its commands as bytes written on the data bus. A write strobe is framed by chip-enable and write-enable both being low. The block samples the address when the strobe opens and the data when it closes. Each closed strobe is one command write. Commands that change the array need two writes: a setup byte, then a confirming write. For programming, the confirming write carries the target address and data, which the block holds so that the buses are free afterwards. Erase and program pulses stay active until the next command write, which ends them.

The block also decodes the signature mode and the two verify modes, and it drives the read-data mux. It contains a small behavioural array that is all ones after reset. A program operation can only clear bits. An erase sets every byte back to all ones. A programming-voltage-present input gates all command acceptance. While it is low, the block is read-only.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in read-array mode. The array holds 8'hFF in every byte, a read returns the array byte at the presented address, and both pulse outputs are low.
- R2: Writing 8'h90 selects signature mode. In this mode a read at address 0 returns 8'h31 and a read at address 1 returns 8'hBD.
- R3: Two consecutive writes of 8'h20 start an erase. After that, every array byte is 8'hFF. `erase_pulse` is high from the confirming write until the next command write, and then drops.
- R4: An erase setup (8'h20) followed by any byte other than 8'h20 returns the block to read-array mode without erasing, and `erase_pulse` stays low.
- R5: Writing 8'h40, then a write carrying address and data, programs that byte to (old AND data). `prog_pulse` is high from that write until the next command write.
- R6: A write takes its address at the opening of the strobe and its data at the close. Changing the address while the strobe is open has no effect on the write.
- R7: Writing 8'hC0 (program verify) or 8'hA0 (erase verify) latches the write's address. Later reads then return the array byte at that latched address, whatever address is presented.
- R8: Writing 8'hFF returns the block to read-array mode. Any byte that is not a known command does the same.
- R9: While `vpp_ok` is low, command writes are ignored and the block is held in read-array mode.
- R10: `dout_en` is high only while both `ce_n` and `oe_n` are low.
- R11: A write-enable pulse with `ce_n` high is not a command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset (power-up) |
| vpp_ok | input | 1 | Programming voltage present; commands accepted only when high |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data bus input (commands and program data) |
| dout | output | 8 | Read data mux output |
| dout_en | output | 1 | Output driver enable; bus is high-impedance when low |
| prog_pulse | output | 1 | Program pulse request to the array |
| erase_pulse | output | 1 | Erase pulse request to the array |
| lat_addr | output | ADDR_W | Address latched for program or verify |
| lat_data | output | 8 | Data latched on the program write |

## Verification
A mode register stuck in the wrong state shows up on the first read after the offending write. The read then returns the array byte, a signature byte or a verify byte where a different one was expected. The pulse outputs reveal a missed pulse end one cycle after the strobe closes. A latch taken on the wrong edge of the strobe only shows when the programmed byte is read back. For that reason the bench moves the address in the middle of a strobe and reads both candidate locations.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
    typedef enum logic [2:0] {
        M_READ,
        M_SIG,
        M_ERASE_SETUP,
        M_ERASING,
        M_ERASE_VFY,
        M_PROG_SETUP,
        M_PROGRAMMING,
        M_PROG_VFY
    } mode_t;

    localparam logic [7:0] CMD_SIG      = 8'h90;
    localparam logic [7:0] CMD_ERASE    = 8'h20;
    localparam logic [7:0] CMD_PROG     = 8'h40;
    localparam logic [7:0] CMD_ERASE_VF = 8'hA0;
    localparam logic [7:0] CMD_PROG_VF  = 8'hC0;
    localparam logic [7:0] CMD_RESET    = 8'hFF;

    localparam logic [7:0] SIG_MAKER    = 8'h31;
    localparam logic [7:0] SIG_DEVICE   = 8'hBD;
endpackage

// File: rtl/fcr_strobe.sv
module fcr_strobe #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              commit,
    output logic [ADDR_W-1:0] wr_addr
);
    typedef struct packed {
        logic              strb;
        logic [ADDR_W-1:0] a;
    } st_t;

    st_t  s_d, s_q;
    logic strb_now;

    always_comb begin
        strb_now = !ce_n && !we_n;
        s_d      = s_q;
        s_d.strb = strb_now;
        if (strb_now && !s_q.strb) begin
            s_d.a = addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign commit  = s_q.strb && !strb_now;
    assign wr_addr = s_q.a;

    // R6: the held address does not move while the strobe stays open
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.strb && strb_now) |=> $stable(s_q.a));
endmodule

// File: rtl/fcr_decoder.sv
module fcr_decoder
    import fcr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vpp_ok,
    input  logic              commit,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    output mode_t             mode,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [7:0]        lat_data,
    output logic              prog_start,
    output logic              erase_start
);
    typedef struct packed {
        mode_t             mode;
        logic [ADDR_W-1:0] la;
        logic [7:0]        ld;
        logic              ps;
        logic              es;
    } dec_t;

    dec_t n_d, n_q;

    always_comb begin
        n_d    = n_q;
        n_d.ps = 1'b0;
        n_d.es = 1'b0;
        if (!vpp_ok) begin
            n_d.mode = M_READ;
        end else if (commit) begin
            case (n_q.mode)
                M_PROG_SETUP: begin
                    n_d.mode = M_PROGRAMMING;
                    n_d.la   = cmd_addr;
                    n_d.ld   = cmd_data;
                    n_d.ps   = 1'b1;
                end
                M_ERASE_SETUP: begin
                    if (cmd_data == CMD_ERASE) begin
                        n_d.mode = M_ERASING;
                        n_d.es   = 1'b1;
                    end else begin
                        n_d.mode = M_READ;
                    end
                end
                default: begin
                    case (cmd_data)
                        CMD_SIG:   n_d.mode = M_SIG;
                        CMD_ERASE: n_d.mode = M_ERASE_SETUP;
                        CMD_PROG:  n_d.mode = M_PROG_SETUP;
                        CMD_ERASE_VF: begin
                            n_d.mode = M_ERASE_VFY;
                            n_d.la   = cmd_addr;
                        end
                        CMD_PROG_VF: begin
                            n_d.mode = M_PROG_VFY;
                            n_d.la   = cmd_addr;
                        end
                        default:   n_d.mode = M_READ;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= '{mode: M_READ, la: '0, ld: '0, ps: 1'b0, es: 1'b0};
        end else begin
            n_q <= n_d;
        end
    end

    assign mode        = n_q.mode;
    assign lat_addr    = n_q.la;
    assign lat_data    = n_q.ld;
    assign prog_start  = n_q.ps;
    assign erase_start = n_q.es;

    // R9: no programming voltage forces read mode on the next cycle
    p_rd_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_ok |=> (n_q.mode == M_READ && !n_q.ps && !n_q.es));
    // R4: a non-confirming byte after erase setup aborts to read
    p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_ok && commit && n_q.mode == M_ERASE_SETUP && cmd_data != CMD_ERASE)
        |=> (n_q.mode == M_READ && !n_q.es));
    // R5: latched program target holds while the pulse runs
    p_lat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q.mode == M_PROGRAMMING && !commit) |=> $stable(n_q.la));
endmodule

// File: rtl/fcr_array.sv
module fcr_array #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_start,
    input  logic              erase_start,
    input  logic [ADDR_W-1:0] wa,
    input  logic [7:0]        wd,
    input  logic [ADDR_W-1:0] ra,
    output logic [7:0]        rd,
    output logic [7:0]        vd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];
    logic [7:0] old_w;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = erase_start ? 8'hFF : mem_q[i];
        end
        if (prog_start && !erase_start) begin
            mem_d[wa] = mem_q[wa] & wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'hFF;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign old_w = mem_q[wa];
    assign rd    = mem_q[ra];
    assign vd    = mem_q[wa];

    // R5: programming only clears bits of the addressed byte
    p_prog_and_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start && !erase_start) |=> (mem_q[$past(wa)] == ($past(old_w) & $past(wd))));
    // R3: erase leaves the first and last bytes all ones
    p_erase_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> (mem_q[0] == 8'hFF && mem_q[DEPTH-1] == 8'hFF));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vpp_ok,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              prog_pulse,
    output logic              erase_pulse,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [7:0]        lat_data
);
    logic              commit;
    logic [ADDR_W-1:0] wr_addr;
    mode_t             mode;
    logic              prog_start;
    logic              erase_start;
    logic [7:0]        arr_rd;
    logic [7:0]        arr_vd;

    fcr_strobe #(.ADDR_W(ADDR_W)) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .addr    (addr),
        .commit  (commit),
        .wr_addr (wr_addr)
    );

    fcr_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .vpp_ok      (vpp_ok),
        .commit      (commit),
        .cmd_addr    (wr_addr),
        .cmd_data    (din),
        .mode        (mode),
        .lat_addr    (lat_addr),
        .lat_data    (lat_data),
        .prog_start  (prog_start),
        .erase_start (erase_start)
    );

    fcr_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_start  (prog_start),
        .erase_start (erase_start),
        .wa          (lat_addr),
        .wd          (lat_data),
        .ra          (addr),
        .rd          (arr_rd),
        .vd          (arr_vd)
    );

    always_comb begin
        case (mode)
            M_SIG: begin
                if (addr == '0)                     dout = SIG_MAKER;
                else if (addr == ADDR_W'(1))        dout = SIG_DEVICE;
                else                                dout = 8'h00;
            end
            M_ERASE_VFY, M_PROG_VFY: dout = arr_vd;
            default:                 dout = arr_rd;
        endcase
    end

    assign dout_en     = !ce_n && !oe_n;
    assign prog_pulse  = (mode == M_PROGRAMMING);
    assign erase_pulse = (mode == M_ERASING);

    // R3, R5: any command write ends a running pulse
    p_pulse_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((prog_pulse || erase_pulse) && commit) |=> !(prog_pulse || erase_pulse));
    // R11: with chip-enable high no write can complete
    p_ce_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && $past(ce_n)) |-> !commit);
endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vpp_ok = 1'b1;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en;
    logic          prog_pulse;
    logic          erase_pulse;
    logic [AW-1:0] lat_addr;
    logic [7:0]    lat_data;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    logic  smp = 1'b0;
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW)) i_flash_cmd_ctrl (
        .clk (clk), .rst_n (rst_n), .vpp_ok (vpp_ok), .ce_n (ce_n), .oe_n (oe_n),
        .we_n (we_n), .addr (addr), .din (din), .dout (dout), .dout_en (dout_en),
        .prog_pulse (prog_pulse), .erase_pulse (erase_pulse),
        .lat_addr (lat_addr), .lat_data (lat_data)
    );

    // monitor: samples midway between the edges
    always @(posedge clk) begin
        #3;
        if (smp && q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = dout;
                1:       act = {7'b0, dout_en};
                2:       act = {7'b0, prog_pulse};
                default: act = {7'b0, erase_pulse};
            endcase
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d, input bit use_ce = 1);
        @(negedge clk);
        addr = a; din = d; ce_n = !use_ce; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic split_write(input logic [AW-1:0] a0, input logic [AW-1:0] a1, input logic [7:0] d);
        @(negedge clk);
        addr = a0; din = 8'h00; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        addr = a1; din = d;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic check(input int kind, input logic [AW-1:0] a, input logic ce, input logic oe,
                         input logic [7:0] exp, input string req);
        item_t it;
        @(negedge clk);
        addr = a; ce_n = ce; oe_n = oe;
        it.kind = kind; it.exp = exp; it.req = req;
        q.push_back(it);
        smp = 1'b1;
        @(negedge clk);
        smp = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        check(0, a, 1'b0, 1'b0, exp, req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(6'd5, 8'hFF, "R1");
        check(2, 6'd0, 1'b0, 1'b0, 8'h00, "R1");
        check(3, 6'd0, 1'b0, 1'b0, 8'h00, "R1");
        // R10 output enable
        check(1, 6'd0, 1'b0, 1'b0, 8'h01, "R10");
        check(1, 6'd0, 1'b0, 1'b1, 8'h00, "R10");
        check(1, 6'd0, 1'b1, 1'b0, 8'h00, "R10");
        // R5 program, pulse until next write
        bus_write(6'd0, 8'h40);
        bus_write(6'd5, 8'h3C);
        check(2, 6'd0, 1'b0, 1'b0, 8'h01, "R5");
        bus_write(6'd0, 8'hFF);
        check(2, 6'd0, 1'b0, 1'b0, 8'h00, "R5");
        rd(6'd5, 8'h3C, "R5");
        bus_write(6'd0, 8'h40);
        bus_write(6'd5, 8'hF0);
        bus_write(6'd0, 8'hFF);
        rd(6'd5, 8'h30, "R5");
        // R6 address at strobe open, data at close
        bus_write(6'd0, 8'h40);
        split_write(6'd7, 6'd9, 8'h0F);
        bus_write(6'd0, 8'hFF);
        rd(6'd7, 8'h0F, "R6");
        rd(6'd9, 8'hFF, "R6");
        // R2 signature, R8 reset command
        bus_write(6'd3, 8'h90);
        rd(6'd0, 8'h31, "R2");
        rd(6'd1, 8'hBD, "R2");
        bus_write(6'd0, 8'hFF);
        rd(6'd0, 8'hFF, "R8");
        bus_write(6'd0, 8'h90);
        bus_write(6'd0, 8'h5A);
        rd(6'd1, 8'hFF, "R8");
        // R7 verify modes
        bus_write(6'd5, 8'hC0);
        rd(6'd20, 8'h30, "R7");
        bus_write(6'd7, 8'hA0);
        rd(6'd33, 8'h0F, "R7");
        bus_write(6'd0, 8'hFF);
        // R4 erase abort
        bus_write(6'd0, 8'h20);
        bus_write(6'd0, 8'h55);
        check(3, 6'd0, 1'b0, 1'b0, 8'h00, "R4");
        rd(6'd5, 8'h30, "R4");
        // R11 write with chip-enable high is ignored
        bus_write(6'd0, 8'h40, 0);
        bus_write(6'd5, 8'h00);
        check(2, 6'd0, 1'b0, 1'b0, 8'h00, "R11");
        rd(6'd5, 8'h30, "R11");
        // R9 no programming voltage
        vpp_ok = 1'b0;
        bus_write(6'd0, 8'h90);
        rd(6'd0, 8'hFF, "R9");
        bus_write(6'd0, 8'h20);
        bus_write(6'd0, 8'h20);
        check(3, 6'd0, 1'b0, 1'b0, 8'h00, "R9");
        rd(6'd5, 8'h30, "R9");
        vpp_ok = 1'b1;
        repeat (2) @(negedge clk);
        // R3 erase
        bus_write(6'd0, 8'h20);
        bus_write(6'd0, 8'h20);
        check(3, 6'd0, 1'b0, 1'b0, 8'h01, "R3");
        bus_write(6'd0, 8'hFF);
        check(3, 6'd0, 1'b0, 1'b0, 8'h00, "R3");
        rd(6'd5, 8'hFF, "R3");
        rd(6'd7, 8'hFF, "R3");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule